// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a 12-bit successive-approximation converter. It resolves one result per conversion by proposing trial codes to an external DAC and sampling a single comparator bit. A falling edge on the active-low write strobe requests a conversion. The sequencer waits for the next rising edge of the conversion clock, pulls the active-low busy flag down, and works from the most significant bit to the least. It then places the finished straight-binary code on its output register and releases busy. Between conversions the analog front end samples, and the sequencer leaves the trial bus at zero.

The bit decisions do not all last the same time. Bit 5 gets two conversion-clock cycles and bit 0 gets one and a half. Every other bit gets one cycle, so a conversion lasts 13.5 conversion cycles. To count half cycles exactly, the block runs on a clock at twice the conversion rate, called the tick clock. An internal phase bit marks which tick edges are conversion-clock rising edges. The comparator input is 1 when the held input is at or above the current trial level.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is high, and right after it, busyN is 1, trialCode is 0 and dataOut is 0.
- R2: The conversion-clock rising edges are the even tick edges. Tick edge 0 is the first edge after reset is released. A conversion starts on the first even tick edge at or after the first edge that samples wrN low after it was high. busyN goes to 0 after that edge.
- R3: busyN stays 0 for exactly 27 tick cycles (13.5 conversion cycles) and then returns to 1.
- R4: Each decision keeps a bit at 1 when cmpHigh is 1 and clears it when cmpHigh is 0. With an ideal comparator (cmpHigh = input code >= trialCode), dataOut equals the input code in straight binary, with bit 11 as the MSB. dataOut updates on the edge where busyN returns to 1.
- R5: trialCode is 0x800 on the first busy cycle. Decisions run from bit 11 down to bit 0. Bit 5 gets 4 ticks, bit 0 gets 3 ticks, and each other bit gets 2 ticks. At the end of a window, the bit under test takes the comparator value and the next lower bit is set to 1.
- R6: A wrN falling edge while busyN is 0 is ignored. A wrN level held low never starts a second conversion.
- R7: While busyN is 1, trialCode is 0 and dataOut holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the conversion clock rate |
| rst | input | 1 | Synchronous active-high reset |
| wrN | input | 1 | Active-low conversion request; its falling edge is used |
| cmpHigh | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| busyN | output | 1 | Active-low conversion-in-progress flag |
| trialCode | output | 12 | Trial code to the DAC |
| dataOut | output | 12 | Last finished conversion result |

## Verification
The hardest case to reach is a request that lands on an odd tick, so that it must wait one tick for a conversion-clock edge. The bench places requests on both tick parities and predicts the start edge from its own count of tick edges. The uneven windows at bits 5 and 0 are observed through the full trial-code trace. This trace is compared on every busy tick against a schedule the bench computes. A second falling edge is placed inside a running conversion, and the line is then held low afterwards. This checks that neither starts a new conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef struct packed {
    logic load;
    logic decide;
    logic finish;
  } sarStrobe_t;

  // ticks granted to the decision of bit idx
  function automatic int winLen(input int idx, input int longBit,
                                input int normHt, input int longHt,
                                input int lastHt);
    if (idx == longBit) return longHt;
    else if (idx == 0) return lastHt;
    else return normHt;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter int LONG_BIT = 5,
  parameter int NORM_HT  = 2,
  parameter int LONG_HT  = 4,
  parameter int LAST_HT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrN,
  output sarStrobe_t               strb,
  output logic [$clog2(NBITS)-1:0] bitIdx,
  output logic                     busyN
);
  localparam int IW = $clog2(NBITS);
  localparam int TW = $clog2(NORM_HT + LONG_HT + LAST_HT + 1);

  logic          phase;
  logic          wrPrev;
  logic          armed;
  logic          converting;
  logic [TW-1:0] tickCnt;
  logic          fall;
  logic          start;
  logic          lastTick;

  always_comb begin
    fall        = wrPrev & ~wrN;
    start       = ~converting & ~phase & (fall | armed);
    lastTick    = converting && (tickCnt == '0);
    strb.load   = start;
    strb.decide = lastTick;
    strb.finish = lastTick && (bitIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      wrPrev     <= 1'b1;
      armed      <= 1'b0;
      converting <= 1'b0;
      bitIdx     <= '0;
      tickCnt    <= '0;
    end else begin
      phase  <= ~phase;
      wrPrev <= wrN;
      armed  <= ~converting & ~start & (armed | fall);
      if (start) begin
        converting <= 1'b1;
        bitIdx     <= IW'(NBITS - 1);
        tickCnt    <= TW'(winLen(NBITS - 1, LONG_BIT, NORM_HT, LONG_HT, LAST_HT) - 1);
      end else if (lastTick) begin
        if (bitIdx == '0) begin
          converting <= 1'b0;
        end else begin
          bitIdx  <= bitIdx - 1'b1;
          tickCnt <= TW'(winLen(int'(bitIdx) - 1, LONG_BIT, NORM_HT, LONG_HT, LAST_HT) - 1);
        end
      end else if (converting) begin
        tickCnt <= tickCnt - 1'b1;
      end
    end
  end

  assign busyN = ~converting;

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  sarStrobe_t               strb,
  input  logic [$clog2(NBITS)-1:0] bitIdx,
  input  logic                     cmpHigh,
  output logic [NBITS-1:0]         trialCode,
  output logic [NBITS-1:0]         dataOut
);
  logic [NBITS-1:0] sarReg;
  logic [NBITS-1:0] decided;
  logic [NBITS-1:0] nextTrial;

  always_comb begin
    decided         = sarReg;
    decided[bitIdx] = cmpHigh;
    nextTrial       = decided;
    if (bitIdx != '0) nextTrial[bitIdx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sarReg  <= '0;
      dataOut <= '0;
    end else if (strb.load) begin
      sarReg <= {1'b1, {(NBITS-1){1'b0}}};
    end else if (strb.finish) begin
      dataOut <= decided;
      sarReg  <= '0;
    end else if (strb.decide) begin
      sarReg <= nextTrial;
    end
  end

  assign trialCode = sarReg;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter int LONG_BIT = 5,
  parameter int NORM_HT  = 2,
  parameter int LONG_HT  = 4,
  parameter int LAST_HT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrN,
  input  logic             cmpHigh,
  output logic             busyN,
  output logic [NBITS-1:0] trialCode,
  output logic [NBITS-1:0] dataOut
);
  localparam int IW = $clog2(NBITS);

  sarStrobe_t    strb;
  logic [IW-1:0] bitIdx;

  sar_seq_ctrl #(
    .NBITS(NBITS), .LONG_BIT(LONG_BIT),
    .NORM_HT(NORM_HT), .LONG_HT(LONG_HT), .LAST_HT(LAST_HT)
  ) i_ctrl (
    .clk(clk), .rst(rst), .wrN(wrN),
    .strb(strb), .bitIdx(bitIdx), .busyN(busyN)
  );

  sar_seq_dpath #(.NBITS(NBITS)) i_dpath (
    .clk(clk), .rst(rst), .strb(strb), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .dataOut(dataOut)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS    = 12,
  parameter int LONG_BIT = 5,
  parameter int NORM_HT  = 2,
  parameter int LONG_HT  = 4,
  parameter int LAST_HT  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busyN,
  input logic [NBITS-1:0] trialCode,
  input logic [NBITS-1:0] dataOut
);
  localparam int TOTAL = (NBITS - 2) * NORM_HT + LONG_HT + LAST_HT;

  logic [7:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rst) lowCnt <= '0;
    else if (busyN) lowCnt <= '0;
    else lowCnt <= lowCnt + 1'b1;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busyN) |-> lowCnt == 8'(TOTAL));

  p_busy_max_r3: assert property (@(posedge clk) disable iff (rst)
    !busyN |-> lowCnt < 8'(TOTAL));

  p_first_trial_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busyN) |-> trialCode == {1'b1, {(NBITS-1){1'b0}}});

  p_idle_trial_r7: assert property (@(posedge clk) disable iff (rst)
    busyN |-> trialCode == '0);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busyN && $past(busyN)) |-> $stable(dataOut));

endmodule

bind sar_seq_top sar_seq_chk #(
  .NBITS(NBITS), .LONG_BIT(LONG_BIT),
  .NORM_HT(NORM_HT), .LONG_HT(LONG_HT), .LAST_HT(LAST_HT)
) i_chk (
  .clk(clk), .rst(rst), .busyN(busyN),
  .trialCode(trialCode), .dataOut(dataOut)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  localparam int NB    = 12;
  localparam int TOTAL = 27;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrN = 1'b1;
  logic [NB-1:0] vin = '0;
  logic          cmpHigh;
  logic          busyN;
  logic [NB-1:0] trialCode;
  logic [NB-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  int edgeCnt = 0;
  bit finished = 0;

  typedef struct { logic [NB-1:0] code; int startEdge; } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  assign cmpHigh = (vin >= trialCode);

  sar_seq_top i_sar_seq_top (
    .clk(clk), .rst(rst), .wrN(wrN), .cmpHigh(cmpHigh),
    .busyN(busyN), .trialCode(trialCode), .dataOut(dataOut)
  );

  always @(posedge clk) if (!rst) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int win(input int b);
    if (b == 5) return 4;
    if (b == 0) return 3;
    return 2;
  endfunction

  function automatic logic [NB-1:0] expTrial(input logic [NB-1:0] code, input int t);
    logic [NB-1:0] acc = '0;
    int cum = 0;
    for (int b = NB - 1; b >= 0; b--) begin
      cum += win(b);
      if (cum <= t) acc[b] = code[b];
      else begin
        acc[b] = 1'b1;
        break;
      end
    end
    return acc;
  endfunction

  // monitor: scoreboard compare
  bit   prevBusyN = 1'b1;
  int   startSeen = 0;
  int   lowTicks  = 0;
  int   traceBad  = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (!rst) begin
      if (prevBusyN && !busyN) begin
        startSeen = edgeCnt - 1;
        lowTicks  = 0;
        traceBad  = 0;
        if (expQ.size() == 0) check(0, "R6 unexpected start", startSeen, -1);
        else begin
          cur = expQ[0];
          check(startSeen == cur.startEdge, "R2 start edge", startSeen, cur.startEdge);
        end
      end
      if (!busyN) begin
        if (trialCode != expTrial(cur.code, edgeCnt - 1 - startSeen)) begin
          traceBad++;
          $display("FAIL R5 trial at tick %0d actual=%0h expected=%0h",
                   edgeCnt - 1 - startSeen, trialCode,
                   expTrial(cur.code, edgeCnt - 1 - startSeen));
        end
        lowTicks++;
      end
      if (!prevBusyN && busyN && expQ.size() != 0) begin
        void'(expQ.pop_front());
        check(lowTicks == TOTAL, "R3 busy length", lowTicks, TOTAL);
        check(dataOut == cur.code, "R4 result code", dataOut, cur.code);
        check(traceBad == 0, "R5 trial trace mismatches", traceBad, 0);
      end
      prevBusyN = busyN;
    end
  end

  // driver: request on a chosen tick parity
  task automatic convert(input logic [NB-1:0] code, input int parity, input bit glitch);
    exp_t e;
    @(negedge clk);
    if ((edgeCnt % 2) != parity) @(negedge clk);
    vin = code;
    e.code = code;
    e.startEdge = (edgeCnt % 2 == 0) ? edgeCnt : edgeCnt + 1;
    expQ.push_back(e);
    wrN = 1'b0;
    repeat (4) @(negedge clk);
    if (glitch) begin
      wrN = 1'b1;
      repeat (3) @(negedge clk);
      wrN = 1'b0;       // falling edge inside the conversion: ignored (R6)
      repeat (2) @(negedge clk);
    end else begin
      wrN = 1'b1;
    end
    while (!busyN) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busyN == 1'b1, "R1 busyN in reset", busyN, 1);
    check(trialCode == '0, "R1 trialCode in reset", trialCode, 0);
    rst = 1'b0;
    @(negedge clk);
    check(dataOut == '0, "R1 dataOut after reset", dataOut, 0);
    check(busyN == 1'b1, "R1 busyN after reset", busyN, 1);

    convert(12'hA5A, 0, 0);
    convert(12'h000, 1, 0);
    convert(12'hFFF, 0, 0);
    convert(12'h800, 1, 0);
    convert(12'h7FF, 0, 0);
    convert(12'h021, 1, 0);

    // R6: glitch during busy, then wrN held low afterwards
    convert(12'h3C7, 1, 1);
    begin
      bit stayed = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!busyN) stayed = 0;
      end
      check(stayed, "R6 no retrigger while held low", busyN, 1);
    end
    check(expQ.size() == 0, "R6 scoreboard empty", expQ.size(), 0);
    check(trialCode == '0, "R7 idle trialCode", trialCode, 0);
    check(dataOut == 12'h3C7, "R7 dataOut held", dataOut, 12'h3C7);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    convert(12'h555, 0, 0);
    check(dataOut == 12'h555, "R4 result after held-low release", dataOut, 12'h555);

    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule